// File: doc/BRIEF.md
# Power Path Selector with Termination Reason Encoder

This block sits in the digital controller of an inductive power receiver. Two static configuration pins choose one of four path modes, which together with a qualified external-supply flag decide between two power sources. One source is a wired supply that reaches the output through an external switch. The other is the wireless rectifier path. The block drives the switch enable and the wireless output enable. A handover between the two paths always opens one path fully before the other one closes.

The block also watches a set of conditions that must end wireless power transfer. These are the host control pin, the thermistor fault, the die thermal flag, a shorted current-limit resistor and a rectifier target that never settles. When any of them is active, the block raises a request to the protocol engine and supplies the 8-bit reason byte that goes into the end-transfer packet. A fixed priority picks the byte when several conditions are active at once. A shorted current-limit resistor must persist for a deglitch window. Once qualified, it is latched until reset, which stands for a power cycle.

All inputs are treated as synchronous to `clk`. Every output is registered.

Top module: `pwr_path_ctl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ext_sw_en`, `wl_en` and `ept_req` are 0 and `ept_code` is 0x00.
- R2: Mode `{cfg_force_ext,cfg_block_ext}=00`. With `ext_present`=1 the target is switch on and wireless off. With `ext_present`=0 the target is wireless on, unless some termination condition is active.
- R3: Mode 01. `ext_sw_en` stays 0 whatever `ext_present` is. `wl_en` targets 1 unless a termination condition is active.
- R4: Mode 10. `ext_sw_en` targets 1 whatever `ext_present` is. `wl_en` stays 0.
- R5: Mode 11. Both `ext_sw_en` and `wl_en` are 0 one cycle later and stay 0.
- R6: `ext_sw_en` and `wl_en` are never 1 together. Either one rises only if the other was 0 in the previous cycle. A path that loses its target drops on the next edge, and the other path rises one edge after that.
- R7: There are five termination sources, each with its own reason byte:
  - mode 00 with `ext_present`=1 gives 0x00;
  - `host_stop`=1 or `cfg_force_ext`=1 gives 0x01;
  - `die_hot`=1 or a latched limit-resistor short gives 0x02;
  - `ntc_fault`=1 gives 0x03;
  - `no_converge`=1 gives 0x08.
  
  `ept_req` and `ept_code` reflect the sources one cycle after they are sampled.
- R8: When several sources are active, `ept_code` carries the smallest reason byte among them.
- R9: `ilim_short` must be sampled high on `DGL_CYC` consecutive cycles before it counts. Once counted, it stays counted, with reason 0x02 requested, until `rst`, even after `ilim_short` returns to 0.
- R10: `ept_code` is 0x00 whenever `ept_req` is 0. Values 0x04 to 0x07 and values above 0x08 never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power cycle) |
| cfg_force_ext | input | 1 | Mode pin A: forces the wired switch on (with B: all off) |
| cfg_block_ext | input | 1 | Mode pin B: blocks the wired source (with A: all off) |
| ext_present | input | 1 | Qualified wired-supply comparator flag (hysteresis applied upstream) |
| host_stop | input | 1 | Host control pin requests end of transfer |
| ntc_fault | input | 1 | Thermistor window fault |
| die_hot | input | 1 | Die thermal shutdown flag |
| ilim_short | input | 1 | Raw current-limit-resistor short comparator |
| no_converge | input | 1 | Rectifier voltage target failed to settle |
| ext_sw_en | output | 1 | Enable for the external wired-path switch |
| wl_en | output | 1 | Enable for the wireless output stage |
| ept_req | output | 1 | End-transfer packet request |
| ept_code | output | 8 | Reason byte for the end-transfer packet |

## Verification
The bench goes after handovers in both directions and after switching straight between the forced-on and the all-off modes. A design that drives both enables in the same edge would show an overlap cycle, and a design that forgets the interlock would show a path rising with the other still on. Random runs with several termination flags active at once expose a priority encoder that returns the highest reason instead of the lowest, or one that leaves a stale code after the request clears. The limit-resistor short is held for one cycle less than the window and then for the full window. It is then released, and finally reset. An off-by-one counter would trip early or late, and a non-sticky flag would clear the 0x02 reason once the comparator falls.

// File: rtl/pwr_path_pkg.sv
package pwr_path_pkg;
  localparam int CODE_W = 8;
  localparam int NSRC   = 5;

  typedef enum logic [1:0] {
    PM_AUTO      = 2'b00,
    PM_WL_ONLY   = 2'b01,
    PM_FORCE_EXT = 2'b10,
    PM_ALL_OFF   = 2'b11
  } path_mode_e;

  // Source index i carries reason src_code(i); indices ascend with code value.
  function automatic logic [CODE_W-1:0] src_code(input int i);
    case (i)
      0:       return 8'h00;
      1:       return 8'h01;
      2:       return 8'h02;
      3:       return 8'h03;
      default: return 8'h08;
    endcase
  endfunction
endpackage

// File: rtl/pp_mode_decode.sv
module pp_mode_decode
  import pwr_path_pkg::*;
(
  input  logic cfg_force_ext,
  input  logic cfg_block_ext,
  input  logic ext_present,
  output logic ext_tgt,
  output logic wl_allowed,
  output logic ext_taking,
  output logic force_term
);
  path_mode_e mode;

  always_comb begin
    mode       = path_mode_e'({cfg_force_ext, cfg_block_ext});
    ext_tgt    = 1'b0;
    wl_allowed = 1'b0;
    ext_taking = 1'b0;
    force_term = 1'b0;
    case (mode)
      PM_AUTO: begin
        ext_tgt    = ext_present;
        ext_taking = ext_present;
        wl_allowed = 1'b1;
      end
      PM_WL_ONLY:   wl_allowed = 1'b1;
      PM_FORCE_EXT: begin
        ext_tgt    = 1'b1;
        force_term = 1'b1;
      end
      default:      force_term = 1'b1;
    endcase
  end
endmodule

// File: rtl/pp_short_latch.sv
module pp_short_latch #(
  parameter int DGL_CYC = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic flag,
  output logic latched
);
  localparam int CW = $clog2(DGL_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DGL_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      latched <= 1'b0;
    end else if (!latched) begin
      if (!flag)            cnt <= '0;
      else if (cnt == LAST) latched <= 1'b1;
      else                  cnt <= cnt + 1'b1;
    end
  end

  AST_SHORT_STICKY: assert property (@(posedge clk) disable iff (rst)
    latched |=> latched); // R9
  AST_SHORT_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(latched) |-> $past(flag)); // R9
endmodule

// File: rtl/pp_ept_prio.sv
module pp_ept_prio
  import pwr_path_pkg::*;
(
  input  logic [NSRC-1:0]   src_act,
  output logic              req,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    req  = |src_act;
    code = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (src_act[i]) code = src_code(i);
    end
  end
endmodule

// File: rtl/pp_handover.sv
module pp_handover (
  input  logic clk,
  input  logic rst,
  input  logic ext_tgt,
  input  logic wl_tgt,
  output logic ext_sw_en,
  output logic wl_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ext_sw_en <= 1'b0;
      wl_en     <= 1'b0;
    end else begin
      ext_sw_en <= ext_tgt && !wl_en;
      wl_en     <= wl_tgt  && !ext_sw_en;
    end
  end

  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (rst)
    !(ext_sw_en && wl_en)); // R6
  AST_EXT_AFTER_WL_OFF: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_sw_en) |-> !$past(wl_en)); // R6
  AST_WL_AFTER_EXT_OFF: assert property (@(posedge clk) disable iff (rst)
    $rose(wl_en) |-> !$past(ext_sw_en)); // R6
endmodule

// File: rtl/pwr_path_ctl.sv
module pwr_path_ctl
  import pwr_path_pkg::*;
#(
  parameter int DGL_CYC = 50000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_force_ext,
  input  logic              cfg_block_ext,
  input  logic              ext_present,
  input  logic              host_stop,
  input  logic              ntc_fault,
  input  logic              die_hot,
  input  logic              ilim_short,
  input  logic              no_converge,
  output logic              ext_sw_en,
  output logic              wl_en,
  output logic              ept_req,
  output logic [CODE_W-1:0] ept_code
);
  logic ext_tgt, wl_allowed, ext_taking, force_term, short_q;
  logic req_c;
  logic [CODE_W-1:0] code_c;
  logic [NSRC-1:0] src;

  pp_mode_decode u_dec (
    .cfg_force_ext(cfg_force_ext), .cfg_block_ext(cfg_block_ext),
    .ext_present(ext_present), .ext_tgt(ext_tgt), .wl_allowed(wl_allowed),
    .ext_taking(ext_taking), .force_term(force_term)
  );

  pp_short_latch #(.DGL_CYC(DGL_CYC)) u_short (
    .clk(clk), .rst(rst), .flag(ilim_short), .latched(short_q)
  );

  assign src = {no_converge, ntc_fault, die_hot | short_q,
                host_stop | force_term, ext_taking};

  pp_ept_prio u_prio (.src_act(src), .req(req_c), .code(code_c));

  pp_handover u_hand (
    .clk(clk), .rst(rst), .ext_tgt(ext_tgt), .wl_tgt(wl_allowed && !req_c),
    .ext_sw_en(ext_sw_en), .wl_en(wl_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ept_req  <= 1'b0;
      ept_code <= '0;
    end else begin
      ept_req  <= req_c;
      ept_code <= code_c;
    end
  end

  AST_NO_REQ_ZERO_CODE: assert property (@(posedge clk) disable iff (rst)
    !ept_req |-> (ept_code == '0)); // R10
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (ept_code <= 8'h03) || (ept_code == 8'h08)); // R10
  AST_BLOCKED_EXT: assert property (@(posedge clk) disable iff (rst)
    (cfg_block_ext && !cfg_force_ext) |=> !ext_sw_en); // R3
  AST_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    (cfg_block_ext && cfg_force_ext) |=> (!ext_sw_en && !wl_en)); // R5
  AST_FORCE_REQ: assert property (@(posedge clk) disable iff (rst)
    cfg_force_ext |=> (ept_req && ept_code <= 8'h01)); // R4
endmodule

// File: tb/pwr_path_ctl_tb.sv
module pwr_path_ctl_tb;
  localparam int DGL = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic f = 0, b = 0, pres = 0, host = 0, ntc = 0, hot = 0, ilim = 0, nc = 0;
  logic ext_sw_en, wl_en, ept_req;
  logic [7:0] ept_code;

  int n_chk = 0, n_fail = 0;
  logic m_ext = 0, m_wl = 0, m_req = 0, m_latch = 0;
  logic [7:0] m_code = 0;
  int m_cnt = 0, m_nsrc = 0;
  logic prev_ext = 0, prev_wl = 0;

  always #10 clk = ~clk;

  pwr_path_ctl #(.DGL_CYC(DGL)) u_dut (
    .clk(clk), .rst(rst), .cfg_force_ext(f), .cfg_block_ext(b),
    .ext_present(pres), .host_stop(host), .ntc_fault(ntc), .die_hot(hot),
    .ilim_short(ilim), .no_converge(nc), .ext_sw_en(ext_sw_en), .wl_en(wl_en),
    .ept_req(ept_req), .ept_code(ept_code)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string mode_tag();
    case ({f, b})
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  // Expected behaviour from the requirements, one clock edge at a time.
  task automatic model_edge();
    logic [4:0] s;
    logic ext_t, wl_t, any;
    logic [7:0] c;
    s[0] = !f && !b && pres;
    s[1] = host || f;
    s[2] = hot || m_latch;
    s[3] = ntc;
    s[4] = nc;
    any = |s;
    c = 8'h00;
    if (s[4]) c = 8'h08;
    if (s[3]) c = 8'h03;
    if (s[2]) c = 8'h02;
    if (s[1]) c = 8'h01;
    if (s[0]) c = 8'h00;
    m_nsrc = $countones(s);
    ext_t = (f && !b) || (!f && !b && pres);
    wl_t  = !f && !any;
    prev_ext = m_ext;
    prev_wl  = m_wl;
    m_ext = ext_t && !prev_wl;
    m_wl  = wl_t && !prev_ext;
    m_req = any;
    m_code = any ? c : 8'h00;
    if (!m_latch) begin
      if (!ilim) m_cnt = 0;
      else if (m_cnt == DGL - 1) m_latch = 1;
      else m_cnt++;
    end
  endtask

  task automatic step();
    string t;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    t = mode_tag();
    chk(t, ext_sw_en, m_ext);
    chk(t, wl_en, m_wl);
    chk("R7", ept_req, m_req);
    if (!m_req) chk("R10", ept_code, 0);
    else if (m_nsrc > 1) chk("R8", ept_code, m_code);
    else chk("R7", ept_code, m_code);
    if (ext_sw_en && !prev_ext) chk("R6", prev_wl, 0);
    if (wl_en && !prev_wl) chk("R6", prev_ext, 0);
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", ext_sw_en, 0);
    chk("R1", wl_en, 0);
    chk("R1", ept_req, 0);
    chk("R1", ept_code, 0);
    m_ext = 0; m_wl = 0; m_req = 0; m_code = 0; m_latch = 0; m_cnt = 0;
    rst = 0;
  endtask

  task automatic clear_in();
    f = 0; b = 0; pres = 0; host = 0; ntc = 0; hot = 0; ilim = 0; nc = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    @(negedge clk);
    do_reset();
    step();
    chk("R1", ext_sw_en, 0);

    // Directed handover in mode 00 (R2, R6)
    repeat (3) step();
    pres = 1; step();
    chk("R6", {ext_sw_en, wl_en}, 2'b00);
    step();
    chk("R2", {ext_sw_en, wl_en}, 2'b10);
    pres = 0; step();
    chk("R6", {ext_sw_en, wl_en}, 2'b00);
    step();
    chk("R2", {ext_sw_en, wl_en}, 2'b01);

    // Mode 01 with adapter present (R3)
    b = 1; pres = 1; repeat (3) step();
    chk("R3", ext_sw_en, 0);
    // Forced on then all off (R4, R5)
    b = 0; f = 1; pres = 0; repeat (3) step();
    chk("R4", ext_sw_en, 1);
    chk("R4", ept_code, 8'h01);
    b = 1; step();
    chk("R5", {ext_sw_en, wl_en}, 2'b00);

    // Priority with every source active (R8)
    clear_in(); pres = 1; host = 1; ntc = 1; hot = 1; nc = 1; step();
    chk("R8", ept_code, 8'h00);
    pres = 0; step();
    chk("R8", ept_code, 8'h01);
    host = 0; step();
    chk("R8", ept_code, 8'h02);

    // Short deglitch window (R9)
    clear_in(); b = 1; repeat (2) step();
    ilim = 1; repeat (DGL - 1) step();
    chk("R9", ept_req, 0);
    ilim = 0; step();
    ilim = 1; repeat (DGL) step();
    step();
    chk("R9", ept_code, 8'h02);
    ilim = 0; repeat (5) step();
    chk("R9", ept_req, 1);
    chk("R9", wl_en, 0);
    do_reset();
    step(); step();
    chk("R9", ept_req, 0);

    // Constrained random
    clear_in();
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 19) == 0) {f, b} = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 9) == 0) pres = ~pres;
      host = ($urandom_range(0, 29) == 0);
      ntc  = ($urandom_range(0, 29) == 0);
      hot  = ($urandom_range(0, 29) == 0);
      nc   = ($urandom_range(0, 29) == 0);
      ilim = ($urandom_range(0, 49) == 0);
      step();
      if (i == 2000) do_reset();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule